// File: doc/BRIEF.md
# Port Power Sourcing Sequencer

This block steers one port of an Ethernet power sourcing controller from an unpowered idle state through detection of an attached device, classification of that device and finally application of power. A 2-bit operating mode decides who moves the port forward. In automatic mode the port runs the whole sequence by itself. In semi-automatic mode it detects and classifies by itself, then waits for the host to grant power. In manual mode every step waits for a host command. A force-on command lets the host power a device that would fail standard detection, such as an older non-compliant device.

The analog front end is abstracted away. Detection arrives as a 2-bit result code, classification as a done strobe with a class code, and an overcurrent fault or disconnect as single-bit inputs. When power is removed, the block reports the cause on one of two separate event outputs. A budget counter times each attempt from the moment the port leaves idle. It raises a pulse if power has not been applied when the budget runs out. The budget is a parameter, so the real limit of 950 ms can be scaled down for simulation.

Top module: `pse_port_seq`

## Requirements
- R1: Mode encoding is 00 off, 01 manual, 10 semi-automatic, 11 automatic. While mode is off, the port returns to idle (state 0) one cycle later, is unpowered, and ignores every command, including force-on.
- R2: In automatic mode the port goes from idle to detect (state 1). A valid detection (code 01) moves it to classify (state 4) with a one-cycle `ev_det_o` pulse. A classification done strobe then moves it to powered (state 6) with a one-cycle `ev_cls_o` pulse. No host command is involved.
- R3: In semi-automatic mode the port detects and classifies on its own. It then stays in ready (state 5) unpowered until `cmd_on_i` is seen, and powers on in the next cycle.
- R4: In manual mode the port stays idle until `cmd_det_i`. After a valid detection it waits in detected (state 3) until `cmd_cls_i`. After classification it waits in ready until `cmd_on_i`.
- R5: An invalid (10) or open (11) detection code sends the port to backoff (state 2) in automatic and semi-automatic modes, and it re-enters detect after exactly RETRY_CYC cycles in backoff. In manual mode the same codes return the port to idle.
- R6: `cmd_force_i` moves the port to powered in the next cycle from any unpowered state when the mode is not off, skipping detection and classification.
- R7: `cmd_on_i` has no effect unless the port is in ready.
- R8: While powered, `fault_i` returns the port to idle with a one-cycle `ev_fault_off_o` pulse. `disc_i` does the same with `ev_disc_off_o`. When both are present, only the fault event is raised.
- R9: The class code is latched into `class_o` when classification completes. It is cleared to 0 when the port enters detect from any other state.
- R10: `budget_miss_o` pulses for one cycle exactly BUDGET_CYC cycles after the port leaves idle, if power has not been applied by then. A sequence that reaches powered sooner raises no pulse.
- R11: `cmd_off_i` returns a powered port to idle without raising either power-off event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Operating mode (00 off, 01 manual, 10 semi, 11 auto) |
| det_code_i | input | 2 | Detection result: 00 none, 01 valid, 10 invalid, 11 open |
| cls_done_i | input | 1 | Classification result available |
| cls_code_i | input | CLS_W | Measured class code |
| fault_i | input | 1 | Overcurrent fault on the powered port |
| disc_i | input | 1 | Device disconnect on the powered port |
| cmd_det_i | input | 1 | Host strobe: start detection |
| cmd_cls_i | input | 1 | Host strobe: start classification |
| cmd_on_i | input | 1 | Host strobe: apply power to a classified port |
| cmd_off_i | input | 1 | Host strobe: remove power |
| cmd_force_i | input | 1 | Host strobe: apply power without detection |
| state_o | output | 3 | Port state code |
| power_o | output | 1 | Port power enabled |
| class_o | output | CLS_W | Latched class |
| ev_det_o | output | 1 | Pulse: valid detection completed |
| ev_cls_o | output | 1 | Pulse: classification completed |
| ev_fault_off_o | output | 1 | Pulse: power removed by overcurrent |
| ev_disc_off_o | output | 1 | Pulse: power removed by disconnect |
| budget_miss_o | output | 1 | Pulse: sequence budget exceeded |

## Verification
The sequence is driven once in each of the three active modes with identical detection and classification inputs, which shows that the only difference between modes is which steps wait for host commands. Valid, invalid and open detection codes are applied in automatic and manual modes, which separates the backoff-and-retry path from the return to idle. Power is removed once by fault, once by disconnect, once by both together and once by host command, which shows that each cause reaches its own event. The budget pulse is checked both on a stalled semi-automatic attempt, for its exact cycle, and on a fast automatic attempt, where it must be absent.

// File: rtl/pse_seq_pkg.sv
// Package: shared encodings for the port power sequencer.
// Assumes: the mode and state codes below are visible at the top-level ports.
package pse_seq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_MANUAL = 2'b01,
        MODE_SEMI   = 2'b10,
        MODE_AUTO   = 2'b11
    } pse_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DETECT   = 3'd1,
        ST_BACKOFF  = 3'd2,
        ST_DETECTED = 3'd3,
        ST_CLASSIFY = 3'd4,
        ST_READY    = 3'd5,
        ST_POWERED  = 3'd6
    } pse_state_e;

    localparam logic [1:0] DET_NONE    = 2'b00;
    localparam logic [1:0] DET_VALID   = 2'b01;
    localparam logic [1:0] DET_INVALID = 2'b10;
    localparam logic [1:0] DET_OPEN    = 2'b11;

    typedef struct packed {
        logic det_done;
        logic cls_done;
        logic fault_off;
        logic disc_off;
    } pse_events_t;

endpackage

// File: rtl/pse_cycle_timer.sv
// Module: pse_cycle_timer
// Counts the cycles during which run_i is high and saturates at LIMIT.
// done_o is high in the LIMIT-th running cycle.
// Assumes LIMIT >= 1. Dropping run_i clears the count in the next cycle.
module pse_cycle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // Counter: clear when idle, advance while running, hold at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal flag for the cycle in which the limit is reached.
    always_comb begin
        done_o = run_i && (cnt_q == LAST);
    end

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && cnt_q == TOP) |-> $past(cnt_q) >= LAST) // R5
        else $error("timer wrapped");

endmodule

// File: rtl/pse_class_latch.sv
// Module: pse_class_latch
// Holds the last class code reported by classification.
// Assumes load_i and clear_i are never high together; clear wins if they are.
module pse_class_latch #(
    parameter int unsigned CLS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [CLS_W-1:0] code_i,
    output logic [CLS_W-1:0] class_o
);
    logic [CLS_W-1:0] class_q;

    // Class register: clear on a new detection, capture on classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_q <= '0;
        end else if (clear_i) begin
            class_q <= '0;
        end else if (load_i) begin
            class_q <= code_i;
        end
    end

    assign class_o = class_q;

    AST_CLASS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> $stable(class_o)) // R9
        else $error("class changed without load");

endmodule

// File: rtl/pse_port_fsm.sv
// Module: pse_port_fsm
// Sequencing state machine for one port.
// Registers the state and the event pulses, so an event appears in the
// same cycle as the state it leads to.
// Assumes: det_code_i counts only in detect, cls_done_i only in classify,
// fault_i and disc_i only while powered.
module pse_port_fsm
    import pse_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  pse_mode_e   mode_i,
    input  logic [1:0]  det_code_i,
    input  logic        cls_done_i,
    input  logic        fault_i,
    input  logic        disc_i,
    input  logic        cmd_det_i,
    input  logic        cmd_cls_i,
    input  logic        cmd_on_i,
    input  logic        cmd_off_i,
    input  logic        cmd_force_i,
    input  logic        retry_done_i,
    output pse_state_e  state_o,
    output pse_events_t events_o,
    output logic        cls_load_o,
    output logic        cls_clear_o
);
    pse_state_e  st_q, st_d;
    pse_events_t ev_q, ev_d;
    logic        is_manual;

    assign is_manual = (mode_i == MODE_MANUAL);

    // Next-state and event decode. Mode off overrides everything.
    always_comb begin
        st_d       = st_q;
        ev_d       = '0;
        cls_load_o = 1'b0;
        if (mode_i == MODE_OFF) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_force_i)                  st_d = ST_POWERED;
                    else if (!is_manual || cmd_det_i) st_d = ST_DETECT;
                end
                ST_DETECT: begin
                    if (cmd_force_i) begin
                        st_d = ST_POWERED;
                    end else begin
                        case (det_code_i)
                            DET_VALID: begin
                                ev_d.det_done = 1'b1;
                                st_d = is_manual ? ST_DETECTED : ST_CLASSIFY;
                            end
                            DET_INVALID, DET_OPEN: begin
                                st_d = is_manual ? ST_IDLE : ST_BACKOFF;
                            end
                            default: st_d = ST_DETECT;
                        endcase
                    end
                end
                ST_BACKOFF: begin
                    if (cmd_force_i)       st_d = ST_POWERED;
                    else if (retry_done_i) st_d = ST_DETECT;
                end
                ST_DETECTED: begin
                    if (cmd_force_i)                  st_d = ST_POWERED;
                    else if (cmd_cls_i || !is_manual) st_d = ST_CLASSIFY;
                end
                ST_CLASSIFY: begin
                    if (cmd_force_i) begin
                        st_d = ST_POWERED;
                    end else if (cls_done_i) begin
                        ev_d.cls_done = 1'b1;
                        cls_load_o    = 1'b1;
                        st_d = (mode_i == MODE_AUTO) ? ST_POWERED : ST_READY;
                    end
                end
                ST_READY: begin
                    if (cmd_force_i || cmd_on_i) st_d = ST_POWERED;
                end
                ST_POWERED: begin
                    if (fault_i) begin
                        ev_d.fault_off = 1'b1;
                        st_d = ST_IDLE;
                    end else if (disc_i) begin
                        ev_d.disc_off = 1'b1;
                        st_d = ST_IDLE;
                    end else if (cmd_off_i) begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Clear the class on any fresh entry into detect.
    always_comb begin
        cls_clear_o = (st_d == ST_DETECT) && (st_q != ST_DETECT);
    end

    // State and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            ev_q <= '0;
        end else begin
            st_q <= st_d;
            ev_q <= ev_d;
        end
    end

    assign state_o  = st_q;
    assign events_o = ev_q;

    AST_OFF_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> (st_q == ST_IDLE)) // R1
        else $error("mode off did not idle the port");

    AST_POWER_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POWERED && $past(st_q) != ST_POWERED) |->
            ($past(cmd_force_i) ||
             ($past(st_q) == ST_READY && $past(cmd_on_i)) ||
             ($past(st_q) == ST_CLASSIFY && $past(mode_i) == MODE_AUTO))) // R7
        else $error("power applied without grant");

    AST_MANUAL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && mode_i == MODE_MANUAL && !cmd_det_i && !cmd_force_i)
            |=> (st_q == ST_IDLE)) // R4
        else $error("manual port left idle by itself");

    AST_READY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && mode_i != MODE_OFF && !cmd_on_i && !cmd_force_i)
            |=> (st_q == ST_READY)) // R3
        else $error("ready port moved without command");

    AST_OFF_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q.fault_off || ev_q.disc_off) |->
            ($past(st_q) == ST_POWERED && st_q == ST_IDLE && !(ev_q.fault_off && ev_q.disc_off))) // R8
        else $error("power-off event without power removal");

    AST_BACKOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BACKOFF && $past(st_q) != ST_BACKOFF) |->
            ($past(st_q) == ST_DETECT && $past(mode_i) != MODE_MANUAL)) // R5
        else $error("backoff entered from wrong state");

endmodule

// File: rtl/pse_port_seq.sv
// Module: pse_port_seq (top)
// Power sourcing sequencer for one port. It combines the state machine,
// a retry timer for backoff, a budget timer for the whole attempt and the
// class register.
// Assumes: all inputs are synchronous to clk; strobes are one cycle wide.
module pse_port_seq
    import pse_seq_pkg::*;
#(
    parameter int unsigned CLS_W      = 3,
    parameter int unsigned RETRY_CYC  = 1000,
    parameter int unsigned BUDGET_CYC = 950000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       det_code_i,
    input  logic             cls_done_i,
    input  logic [CLS_W-1:0] cls_code_i,
    input  logic             fault_i,
    input  logic             disc_i,
    input  logic             cmd_det_i,
    input  logic             cmd_cls_i,
    input  logic             cmd_on_i,
    input  logic             cmd_off_i,
    input  logic             cmd_force_i,
    output logic [2:0]       state_o,
    output logic             power_o,
    output logic [CLS_W-1:0] class_o,
    output logic             ev_det_o,
    output logic             ev_cls_o,
    output logic             ev_fault_off_o,
    output logic             ev_disc_off_o,
    output logic             budget_miss_o
);
    pse_state_e  st;
    pse_events_t ev;
    logic        retry_done;
    logic        budget_done;
    logic        budget_run;
    logic        cls_load;
    logic        cls_clear;
    logic        miss_q;

    pse_port_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (pse_mode_e'(mode_i)),
        .det_code_i   (det_code_i),
        .cls_done_i   (cls_done_i),
        .fault_i      (fault_i),
        .disc_i       (disc_i),
        .cmd_det_i    (cmd_det_i),
        .cmd_cls_i    (cmd_cls_i),
        .cmd_on_i     (cmd_on_i),
        .cmd_off_i    (cmd_off_i),
        .cmd_force_i  (cmd_force_i),
        .retry_done_i (retry_done),
        .state_o      (st),
        .events_o     (ev),
        .cls_load_o   (cls_load),
        .cls_clear_o  (cls_clear)
    );

    pse_cycle_timer #(.LIMIT(RETRY_CYC)) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st == ST_BACKOFF),
        .done_o (retry_done)
    );

    // Budget runs for as long as an attempt is in flight and unpowered.
    always_comb begin
        budget_run = (st != ST_IDLE) && (st != ST_POWERED);
    end

    pse_cycle_timer #(.LIMIT(BUDGET_CYC)) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (budget_run),
        .done_o (budget_done)
    );

    pse_class_latch #(.CLS_W(CLS_W)) u_class (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cls_load),
        .clear_i (cls_clear),
        .code_i  (cls_code_i),
        .class_o (class_o)
    );

    // Register the budget miss into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_q <= 1'b0;
        else        miss_q <= budget_done;
    end

    assign state_o        = st;
    assign power_o        = (st == ST_POWERED);
    assign ev_det_o       = ev.det_done;
    assign ev_cls_o       = ev.cls_done;
    assign ev_fault_off_o = ev.fault_off;
    assign ev_disc_off_o  = ev.disc_off;
    assign budget_miss_o  = miss_q;

    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        budget_miss_o |=> !budget_miss_o) // R10
        else $error("budget miss longer than one cycle");

    AST_MISS_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        budget_miss_o |-> ($past(st) != ST_IDLE && $past(st) != ST_POWERED)) // R10
        else $error("budget miss while not in an attempt");

endmodule

// File: tb/tb_pse_port_seq.sv
module tb_pse_port_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLS_W      = 3;
    localparam int RETRY      = 5;
    localparam int BUDGET     = 40;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] mode, det_code;
    logic cls_done, fault, disc;
    logic [CLS_W-1:0] cls_code;
    logic cmd_det, cmd_cls, cmd_on, cmd_off, cmd_force;
    logic [2:0] state;
    logic power, ev_det, ev_cls, ev_fault, ev_disc, miss;
    logic [CLS_W-1:0] cls;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pse_port_seq #(.CLS_W(CLS_W), .RETRY_CYC(RETRY), .BUDGET_CYC(BUDGET)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .det_code_i(det_code),
        .cls_done_i(cls_done), .cls_code_i(cls_code), .fault_i(fault), .disc_i(disc),
        .cmd_det_i(cmd_det), .cmd_cls_i(cmd_cls), .cmd_on_i(cmd_on), .cmd_off_i(cmd_off),
        .cmd_force_i(cmd_force), .state_o(state), .power_o(power), .class_o(cls),
        .ev_det_o(ev_det), .ev_cls_o(ev_cls), .ev_fault_off_o(ev_fault),
        .ev_disc_off_o(ev_disc), .budget_miss_o(miss)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clr_in();
        det_code = 2'b00; cls_done = 1'b0; cls_code = '0; fault = 1'b0; disc = 1'b0;
        cmd_det = 1'b0; cmd_cls = 1'b0; cmd_on = 1'b0; cmd_off = 1'b0; cmd_force = 1'b0;
    endtask

    task automatic go_off();
        clr_in(); mode = 2'b00; tick();
    endtask

    // Auto mode: from idle to powered with no host command.
    task automatic auto_to_power(input logic [CLS_W-1:0] c);
        mode = 2'b11; tick();
        chk("R2", "auto enters detect", state, 1);
        chk("R9", "class cleared on detect", cls, 0);
        det_code = 2'b01; tick(); det_code = 2'b00;
        chk("R2", "auto classify", state, 4);
        chk("R2", "detect event", ev_det, 1);
        cls_done = 1'b1; cls_code = c; tick(); cls_done = 1'b0;
        chk("R2", "auto powered", state, 6);
        chk("R2", "power on", power, 1);
        chk("R2", "class event", ev_cls, 1);
        chk("R9", "class latched", cls, c);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; clr_in(); mode = 2'b11;
        repeat (3) tick();
        chk("R1", "reset state", state, 0);
        chk("R1", "reset power", power, 0);
        chk("R9", "reset class", cls, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_auto_faults();
        go_off();
        auto_to_power(3'd3);
        fault = 1'b1; tick(); fault = 1'b0;
        chk("R8", "fault to idle", state, 0);
        chk("R8", "fault event", ev_fault, 1);
        chk("R8", "no disc event", ev_disc, 0);
        tick();
        chk("R9", "redetect clears class", cls, 0);
        chk("R2", "auto redetect", state, 1);
        go_off();
        auto_to_power(3'd2);
        disc = 1'b1; tick(); disc = 1'b0;
        chk("R8", "disc event", ev_disc, 1);
        chk("R8", "disc no fault event", ev_fault, 0);
        go_off();
        auto_to_power(3'd1);
        fault = 1'b1; disc = 1'b1; tick(); clr_in();
        chk("R8", "both: fault event", ev_fault, 1);
        chk("R8", "both: no disc event", ev_disc, 0);
    endtask

    task automatic test_semi();
        go_off();
        mode = 2'b10; tick();
        chk("R3", "semi detect", state, 1);
        det_code = 2'b01; tick(); det_code = 2'b00;
        chk("R3", "semi classify", state, 4);
        cmd_on = 1'b1; tick(); cmd_on = 1'b0;
        chk("R7", "on ignored in classify", state, 4);
        cls_done = 1'b1; cls_code = 3'd4; tick(); cls_done = 1'b0;
        chk("R3", "semi ready", state, 5);
        repeat (3) tick();
        chk("R3", "semi waits unpowered", power, 0);
        cmd_on = 1'b1; tick(); cmd_on = 1'b0;
        chk("R3", "semi powered on command", power, 1);
        cmd_off = 1'b1; tick(); cmd_off = 1'b0;
        chk("R11", "off command to idle", state, 0);
        chk("R11", "no event on off command", {ev_fault, ev_disc}, 0);
    endtask

    task automatic test_manual();
        go_off();
        mode = 2'b01; cmd_on = 1'b1; tick(); cmd_on = 1'b0;
        chk("R7", "on ignored in idle", state, 0);
        tick();
        chk("R4", "manual holds idle", state, 0);
        cmd_det = 1'b1; tick(); cmd_det = 1'b0;
        chk("R4", "manual detect", state, 1);
        det_code = 2'b01; tick(); det_code = 2'b00;
        chk("R4", "manual detected", state, 3);
        tick();
        chk("R4", "manual waits class cmd", state, 3);
        cmd_cls = 1'b1; tick(); cmd_cls = 1'b0;
        chk("R4", "manual classify", state, 4);
        cls_done = 1'b1; cls_code = 3'd0; tick(); cls_done = 1'b0;
        chk("R4", "manual ready", state, 5);
        cmd_on = 1'b1; tick(); cmd_on = 1'b0;
        chk("R4", "manual powered", state, 6);
        go_off();
        mode = 2'b01; cmd_det = 1'b1; tick(); cmd_det = 1'b0;
        det_code = 2'b10; tick(); det_code = 2'b00;
        chk("R5", "manual invalid to idle", state, 0);
    endtask

    task automatic test_retry();
        go_off();
        mode = 2'b11; tick();
        det_code = 2'b11; tick(); det_code = 2'b00;
        chk("R5", "open to backoff", state, 2);
        repeat (RETRY - 1) tick();
        chk("R5", "still backoff", state, 2);
        tick();
        chk("R5", "retry detect", state, 1);
        det_code = 2'b10; tick(); det_code = 2'b00;
        chk("R5", "invalid to backoff", state, 2);
    endtask

    task automatic test_force();
        go_off();
        mode = 2'b01; cmd_force = 1'b1; tick(); cmd_force = 1'b0;
        chk("R6", "force from manual idle", state, 6);
        go_off();
        mode = 2'b10; tick();
        cmd_force = 1'b1; tick(); cmd_force = 1'b0;
        chk("R6", "force from detect", power, 1);
        mode = 2'b00; tick();
        chk("R1", "off removes power", power, 0);
        chk("R1", "off no event", {ev_fault, ev_disc}, 0);
        cmd_force = 1'b1; cmd_det = 1'b1; tick(); tick(); clr_in();
        chk("R1", "commands ignored when off", state, 0);
    endtask

    task automatic test_budget();
        int bad;
        go_off();
        mode = 2'b10; tick();
        chk("R10", "budget attempt starts", state, 1);
        det_code = 2'b01;
        bad = 0;
        for (int i = 1; i <= BUDGET; i++) begin
            tick();
            if (i == 1) begin det_code = 2'b00; cls_done = 1'b1; end
            if (i == 2) cls_done = 1'b0;
            if (miss !== (i == BUDGET)) bad++;
        end
        chk("R10", "miss pulse cycle mismatches", bad, 0);
        go_off();
        auto_to_power(3'd1);
        bad = 0;
        for (int i = 0; i < BUDGET + 5; i++) begin
            tick();
            if (miss !== 1'b0) bad++;
        end
        chk("R10", "no miss on fast attempt", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        test_auto_faults();
        test_semi();
        test_manual();
        test_retry();
        test_force();
        test_budget();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule